// File: doc/BRIEF.md
# Cursor and Overscan Colour Triplet Port

This block holds a small auxiliary colour table of sixteen 24-bit entries, each made of one 8-bit red, green and blue component. It serves cursor and border colours next to a larger main palette. Software reaches it through three byte-wide registers: a write-address register, a read-address register and a data register. The data register moves one colour component per access. Components always go red first, then green, then blue. One position counter is shared by reads and writes, and any address-register write puts it back to red.

Entry 0 also drives a 24-bit overscan colour output. When the enable input is high and a full triplet is committed to entry 0, the output takes the new colour. At all other times the output holds its value. Read data comes back one cycle after the request and is marked by a valid strobe. Each component read returns only its low six bits.

Top module: `aux_cursor_palette`

## Requirements
- R1: After reset, both indices are 0, the position is red, the status byte is 0x00, all entries are zero, `ovs_color` is zero and `rd_valid` is low.
- R2: A write to select 0 (write address) with value v sets the write index to v mod 16 and the read index to (v-1) mod 16. It also sets the position to red. A read of select 0 returns the write index in the low four bits, with zeros above.
- R3: A write to select 2 (read address) with value v sets the read index to v mod 16, sets the position to red and sets the status byte to 0x03. A read of select 2 returns the status byte.
- R4: Writes to select 1 (data) are taken as red, then green, then blue. The entry at the write index changes only on the blue write, which stores {red,green,blue} and then advances the write index modulo 16 (15 wraps to 0).
- R5: Reads of select 1 return red, then green, then blue of the entry at the read index, each masked to its low six bits. After blue the read index advances modulo 16 and the position returns to red.
- R6: Any data-register access, read or write, clears the status byte to 0x00. A write-address load also leaves it at 0x00.
- R7: `ovs_color` takes {red,green,blue} on the cycle after a blue write that commits entry 0 while `ovs_en` is high. Otherwise it holds, including for commits with `ovs_en` low and commits to other entries.
- R8: An address-register write during a partial triplet drops the collected components. The entry is left unchanged, and the next data access starts again at red.
- R9: When `wr_en` and `rd_en` are both high in one cycle, the write is performed and the read is ignored: no `rd_valid` pulse and no read-side state change.
- R10: `rd_data` and `rd_valid` appear on the clock edge that follows the edge sampling `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 write address, 1 data, 2 read address / status |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Read data byte, registered |
| rd_valid | output | 1 | High for one cycle when `rd_data` holds a read result |
| ovs_en | input | 1 | Allows commits of entry 0 to update the overscan output |
| ovs_color | output | 24 | Overscan colour {red, green, blue} |

## Verification
A wrong shared position shows up at the next data access. A component lands in the wrong channel, or a triplet commits early or late, and this is seen on the first read-back of that entry or at `ovs_color` one cycle after the blue write. A read index that is off by one after a write-address load, or one that does not wrap, returns a neighbouring entry's colour on the very next data read. A stuck status byte is exposed by a read of select 2 straight after one data access. The bench drives long runs that cross index 15, so wrap faults are seen within one triplet.

// File: rtl/aux_pal_pkg.sv
package aux_pal_pkg;

  typedef enum logic [1:0] {
    SEL_WADDR = 2'd0,
    SEL_DATA  = 2'd1,
    SEL_RADDR = 2'd2,
    SEL_SPARE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    POS_RED   = 2'd0,
    POS_GREEN = 2'd1,
    POS_BLUE  = 2'd2
  } comp_pos_e;

  localparam logic [7:0] STATUS_RD_LOADED = 8'h03;

endpackage

// File: rtl/aux_pal_seq.sv
module aux_pal_seq
  import aux_pal_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int COMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_acc,
  input  logic              rd_acc,
  input  reg_sel_e          sel,
  input  logic [COMP_W-1:0] wdata,
  output logic [IDX_W-1:0]  widx,
  output logic [IDX_W-1:0]  ridx,
  output comp_pos_e         pos,
  output logic [7:0]        status,
  output logic [COMP_W-1:0] held_r,
  output logic [COMP_W-1:0] held_g,
  output logic              commit,
  output logic              data_rd
);

  logic data_wr;
  logic [IDX_W-1:0] load_val;

  function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] i, input logic up);
    return up ? IDX_W'(i + 1'b1) : IDX_W'(i - 1'b1);
  endfunction

  assign load_val = wdata[IDX_W-1:0];
  assign data_wr  = wr_acc && (sel == SEL_DATA);
  assign data_rd  = rd_acc && (sel == SEL_DATA);
  assign commit   = data_wr && (pos == POS_BLUE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      widx   <= '0;
      ridx   <= '0;
      pos    <= POS_RED;
      status <= '0;
      held_r <= '0;
      held_g <= '0;
    end else if (wr_acc && sel == SEL_WADDR) begin
      widx   <= load_val;
      ridx   <= idx_step(load_val, 1'b0);
      pos    <= POS_RED;
      status <= '0;
    end else if (wr_acc && sel == SEL_RADDR) begin
      ridx   <= load_val;
      pos    <= POS_RED;
      status <= STATUS_RD_LOADED;
    end else if (data_wr) begin
      status <= '0;
      unique case (pos)
        POS_RED:   begin held_r <= wdata; pos <= POS_GREEN; end
        POS_GREEN: begin held_g <= wdata; pos <= POS_BLUE;  end
        default:   begin widx <= idx_step(widx, 1'b1); pos <= POS_RED; end
      endcase
    end else if (data_rd) begin
      status <= '0;
      unique case (pos)
        POS_RED:   pos <= POS_GREEN;
        POS_GREEN: pos <= POS_BLUE;
        default:   begin ridx <= idx_step(ridx, 1'b1); pos <= POS_RED; end
      endcase
    end
  end

  // R2: write-address load leaves read index one below write index
  assert_addr_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && sel == SEL_WADDR) |=> (IDX_W'(widx - 1'b1) == ridx && pos == POS_RED));

  assert_commit_adv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (widx == IDX_W'($past(widx) + 1'b1)));

  assert_read_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && pos == POS_BLUE) |=> (ridx == IDX_W'($past(ridx) + 1'b1) && pos == POS_RED));

  assert_pos_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pos != SEL_SPARE);

  assert_status_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr || data_rd) |=> (status == 8'h00));

endmodule

// File: rtl/aux_pal_store.sv
module aux_pal_store
  import aux_pal_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int COMP_W  = 8,
  parameter int RD_W    = 6,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ENT_W  = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [IDX_W-1:0]  widx,
  input  logic [ENT_W-1:0]  wentry,
  input  logic [IDX_W-1:0]  ridx,
  input  comp_pos_e         pos,
  output logic [COMP_W-1:0] rcomp
);

  logic [ENT_W-1:0] mem [ENTRIES];
  logic [ENT_W-1:0] rentry;
  logic [COMP_W-1:0] raw;

  function automatic logic [COMP_W-1:0] trim_comp(input logic [COMP_W-1:0] c);
    logic [COMP_W-1:0] keep;
    keep = '0;
    keep[RD_W-1:0] = '1;
    return c & keep;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
    end else if (commit) begin
      mem[widx] <= wentry;
    end
  end

  assign rentry = mem[ridx];

  always_comb begin
    unique case (pos)
      POS_RED:   raw = rentry[3*COMP_W-1:2*COMP_W];
      POS_GREEN: raw = rentry[2*COMP_W-1:COMP_W];
      default:   raw = rentry[COMP_W-1:0];
    endcase
  end

  assign rcomp = trim_comp(raw);

  assert_rd_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rcomp[COMP_W-1:RD_W] == '0);

endmodule

// File: rtl/aux_cursor_palette.sv
module aux_cursor_palette
  import aux_pal_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int COMP_W  = 8,
  parameter int RD_W    = 6,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int ENT_W  = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [COMP_W-1:0] wr_data,
  output logic [COMP_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              ovs_en,
  output logic [ENT_W-1:0]  ovs_color
);

  reg_sel_e         sel;
  logic             wr_acc, rd_acc;
  logic [IDX_W-1:0] widx, ridx;
  comp_pos_e        pos;
  logic [7:0]       status;
  logic [COMP_W-1:0] held_r, held_g, rcomp;
  logic             commit, data_rd;
  logic [ENT_W-1:0] wentry;
  logic             commit_ovs;
  logic [COMP_W-1:0] rd_mux;

  assign sel    = reg_sel_e'(reg_sel);
  assign wr_acc = wr_en;
  assign rd_acc = rd_en && !wr_en;
  assign wentry = {held_r, held_g, wr_data};
  assign commit_ovs = commit && ovs_en && (widx == '0);

  aux_pal_seq #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .rd_acc(rd_acc), .sel(sel),
    .wdata(wr_data), .widx(widx), .ridx(ridx), .pos(pos), .status(status),
    .held_r(held_r), .held_g(held_g), .commit(commit), .data_rd(data_rd)
  );

  aux_pal_store #(.ENTRIES(ENTRIES), .COMP_W(COMP_W), .RD_W(RD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit), .widx(widx), .wentry(wentry),
    .ridx(ridx), .pos(pos), .rcomp(rcomp)
  );

  always_comb begin
    rd_mux = '0;
    unique case (sel)
      SEL_WADDR: rd_mux[IDX_W-1:0] = widx;
      SEL_DATA:  rd_mux = rcomp;
      SEL_RADDR: rd_mux = COMP_W'(status);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_acc;
      if (rd_acc) rd_data <= rd_mux;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovs_color <= '0;
    else if (commit_ovs) ovs_color <= wentry;
  end

  assert_ovs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_ovs |=> $stable(ovs_color));

  assert_ovs_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ovs |=> (ovs_color[COMP_W-1:0] == $past(wr_data)));

  assert_collide_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en) |=> !rd_valid);

  assert_rd_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_valid == !$past(wr_en)));

endmodule

// File: tb/aux_cursor_palette_tb.sv
`timescale 1ns/1ps
module aux_cursor_palette_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic wr_en = 1'b0, rd_en = 1'b0, ovs_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic rd_valid;
  logic [23:0] ovs_color;

  always #2.5 clk = ~clk;

  aux_cursor_palette u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .ovs_en(ovs_en), .ovs_color(ovs_color)
  );

  typedef struct { logic [7:0] val; string req; } exp_t;
  exp_t sb[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;

  // reference state, built from the requirements
  logic [23:0] m_mem [16];
  int m_w = 0, m_r = 0, m_pos = 0;
  logic [7:0] m_rh = 0, m_gh = 0, m_stat = 0;
  logic [23:0] m_ovs = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus(input logic [1:0] s, input logic w, input logic r, input logic [7:0] v);
    reg_sel = s; wr_en = w; rd_en = r; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic model_write(input logic [1:0] s, input logic [7:0] v);
    case (s)
      2'd0: begin m_w = v & 15; m_r = (v - 1) & 15; m_pos = 0; m_stat = 8'h00; end
      2'd2: begin m_r = v & 15; m_pos = 0; m_stat = 8'h03; end
      2'd1: begin
        m_stat = 8'h00;
        if (m_pos == 0) begin m_rh = v; m_pos = 1; end
        else if (m_pos == 1) begin m_gh = v; m_pos = 2; end
        else begin
          m_mem[m_w] = {m_rh, m_gh, v};
          if (ovs_en && m_w == 0) m_ovs = {m_rh, m_gh, v};
          m_w = (m_w + 1) & 15; m_pos = 0;
        end
      end
      default: ;
    endcase
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] v);
    model_write(s, v);
    bus(s, 1'b1, 1'b0, v);
  endtask

  task automatic rd(input logic [1:0] s, input string req);
    exp_t e;
    e.req = req;
    case (s)
      2'd0: e.val = 8'(m_w);
      2'd2: e.val = m_stat;
      2'd1: begin
        m_stat = 8'h00;
        e.val = 8'((m_mem[m_r] >> (8 * (2 - m_pos))) & 24'h3f);
        if (m_pos == 2) begin m_r = (m_r + 1) & 15; m_pos = 0; end
        else m_pos++;
      end
      default: e.val = 8'h00;
    endcase
    sb.push_back(e);
    bus(s, 1'b0, 1'b1, 8'h00);
  endtask

  task automatic wr_rgb(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    wr(2'd1, r); wr(2'd1, g); wr(2'd1, b);
  endtask

  // monitor: R10 results appear on the edge after the request
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 unexpected read result actual=%0h expected=none", rd_data);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, {24'h0, rd_data}, {24'h0, e.val});
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = 24'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ovs reset", ovs_color, 24'h0);
    check("R1 rd_valid reset", rd_valid, 0);
    rd(2'd0, "R1 write index");
    rd(2'd2, "R1 status");
    rd(2'd1, "R1 entry red");

    // R7: commit of entry 0 with enable
    ovs_en = 1'b1;
    wr(2'd0, 8'h00);
    wr_rgb(8'hFF, 8'h80, 8'h3C);
    @(negedge clk);
    check("R7 ovs load", ovs_color, m_ovs);

    // R2: load, read back, read index is one below
    wr(2'd0, 8'h25);
    rd(2'd0, "R2 write index readback");
    rd(2'd2, "R6 status after write-address load");
    wr(2'd0, 8'h00);
    wr_rgb(8'h11, 8'h22, 8'h33);
    wr(2'd0, 8'h01);
    rd(2'd1, "R2 preset read index red");
    rd(2'd1, "R2 preset read index green");
    rd(2'd1, "R2 preset read index blue");

    // R4: write run across wrap 15 -> 0; entry 0 with enable updates ovs
    wr(2'd0, 8'h0E);
    wr_rgb(8'hC1, 8'hD2, 8'hE3);
    wr_rgb(8'h45, 8'h56, 8'h67);
    wr_rgb(8'h7A, 8'h8B, 8'h9C);
    rd(2'd0, "R4 write index wrapped");
    @(negedge clk);
    check("R7 ovs after wrap commit", ovs_color, m_ovs);

    // R7 hold: enable low, commit entry 0; also other entry with enable high
    ovs_en = 1'b0;
    wr(2'd0, 8'h00);
    wr_rgb(8'h01, 8'h02, 8'h03);
    @(negedge clk);
    check("R7 hold with enable low", ovs_color, 24'h7A8B9C);
    ovs_en = 1'b1;
    wr_rgb(8'hAA, 8'hBB, 8'hCC);
    @(negedge clk);
    check("R7 hold on other entry", ovs_color, 24'h7A8B9C);

    // R3/R5: read run across wrap with masking
    wr(2'd2, 8'h0E);
    rd(2'd2, "R3 status after read-address load");
    for (int k = 0; k < 9; k++) rd(2'd1, "R5 masked read run");
    rd(2'd2, "R6 status after data read");
    rd(2'd1, "R5 read index after wrap");

    // R8: partial triplet dropped
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h99); wr(2'd1, 8'h88);
    wr(2'd2, 8'h03);
    rd(2'd1, "R8 entry untouched red");
    rd(2'd1, "R8 entry untouched green");
    rd(2'd1, "R8 entry untouched blue");
    wr(2'd0, 8'h03);
    wr(2'd1, 8'h77);
    wr(2'd0, 8'h03);
    wr_rgb(8'h3F, 8'h2E, 8'h1D);
    wr(2'd2, 8'h03);
    rd(2'd1, "R8 restart red");
    rd(2'd1, "R8 restart green");
    rd(2'd1, "R8 restart blue");

    // R6: data write clears status
    wr(2'd2, 8'h05);
    wr(2'd1, 8'h10);
    rd(2'd2, "R6 status after data write");

    // R9: collision, write wins
    wr(2'd0, 8'h08);
    model_write(2'd1, 8'h21);
    bus(2'd1, 1'b1, 1'b1, 8'h21);
    model_write(2'd1, 8'h32);
    bus(2'd1, 1'b1, 1'b1, 8'h32);
    model_write(2'd1, 8'h2B);
    bus(2'd1, 1'b1, 1'b1, 8'h2B);
    @(negedge clk);
    check("R9 no read on collision", rd_valid, 0);
    rd(2'd0, "R9 write index advanced");
    wr(2'd2, 8'h08);
    rd(2'd1, "R9 written red");
    rd(2'd1, "R9 written green");
    rd(2'd1, "R9 written blue");

    repeat (3) @(negedge clk);
    check("R10 all reads returned", sb.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule